// File: doc/BRIEF.md
# Forward/Inverse 5/3 Integer Lifting Core

This block computes one level of the reversible 5/3 integer wavelet transform in either direction on a continuous stream. It has two lifting elements. Each one forms the sum of two operands, shifts it right with floor rounding, and adds the result to a third operand or subtracts it. A mode pin selects the direction. In forward mode a sample stream is split into even/odd pairs, and each pair yields one low-pass/high-pass coefficient pair. In inverse mode coefficient pairs enter, and the rebuilt samples leave one per transfer, even sample first.

The computation is causal. All history registers start at zero after reset, so the transform treats the stream as if one zero pair came before it. When the forward output is fed back through the inverse path, the result is the original stream with four leading zeros. A register between the two elements keeps the longest path to a single element. Data words are 11-bit signed two's complement and wrap modulo 2^11.

Every stream port is valid/ready. A transfer happens on a rising edge where both valid and ready are high. Once valid is raised, data and valid stay unchanged until that transfer. Readiness may depend on the downstream ready of the same cycle. The mode must not change except while reset is asserted.

Top module: `lift53_core`

## Requirements
- R1: Each element returns base minus or plus the floor of (opa+opb)/2^k, truncated to 11 bits. The add/subtract bit set to 1 means subtract. The shift bit set to 1 means k=1, and 0 means k=2. In forward mode, element 0 predicts (subtract, k=1) and element 1 updates (add, k=2). In inverse mode, element 0 undoes the update (subtract, k=2) and element 1 undoes the prediction (add, k=1).
- R2: In forward mode (mode=0), accepted samples alternate even, odd, even, starting with even after reset. For every pair (e_j, o_j), one coefficient pair is emitted, one pair behind the input. For each j ≥ -1: hi = d_j = o_j − floor((e_j+e_{j+1})/2) and lo = a_j = e_j + floor((d_{j−1}+d_j)/4). Here e_{-1} = o_{-1} = d_{-2} = 0.
- R3: In inverse mode (mode=1), each accepted pair (lo=a_j, hi=d_j) gives e_j = a_j − floor((d_{j−1}+d_j)/4) and o_{j−1} = d_{j−1} + floor((e_{j−1}+e_j)/2). The output delivers e_{j−1} and then o_{j−1}. Feeding the forward output back returns the input stream delayed by four zero samples.
- R4: In mode 0, the coefficient input ready, sample output valid and sample output data stay zero. In mode 1, the sample input ready, coefficient output valid and coefficient output data stay zero. Traffic on the unused input port leaves the internal state unchanged.
- R5: An output whose valid is high and whose ready is low keeps valid and data unchanged in the next cycle. Under any pattern of back-pressure, no word is lost or duplicated.
- R6: Reset (rst_n low, synchronous) clears every valid, the pairing phase and all history. Right after reset, both output valids are low.
- R7: With no back-pressure in forward mode, the coefficient pair becomes valid in the second cycle after the edge that accepts the odd sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 forward, 1 inverse |
| in_smp_valid | input | 1 | Sample input valid (forward) |
| in_smp_ready | output | 1 | Sample input ready |
| in_smp_data | input | 11 | Sample input word |
| in_cf_valid | input | 1 | Coefficient input valid (inverse) |
| in_cf_ready | output | 1 | Coefficient input ready |
| in_cf_lo | input | 11 | Low-pass coefficient in |
| in_cf_hi | input | 11 | High-pass coefficient in |
| out_cf_valid | output | 1 | Coefficient output valid (forward) |
| out_cf_ready | input | 1 | Coefficient output ready |
| out_cf_lo | output | 11 | Low-pass coefficient out |
| out_cf_hi | output | 11 | High-pass coefficient out |
| out_smp_valid | output | 1 | Sample output valid (inverse) |
| out_smp_ready | input | 1 | Sample output ready |
| out_smp_data | output | 11 | Rebuilt sample out |

## Verification
Two things can happen in the same cycle. A new pair can enter element 0 and update its history while the output register is frozen by back-pressure. A pair can also move from the middle register into the output just as the output register is freed. The bench provokes both by driving the output ready from a pseudo-random pattern during long forward and inverse runs. It judges the result by exact word-for-word agreement with a model computed from the lifting equations and by bit-exact reconstruction after the round trip. Any lost, repeated or stale history update shows up as a mismatch.

// File: rtl/lift53_pkg.sv
package lift53_pkg;

  typedef enum logic {
    MODE_FWD = 1'b0,
    MODE_INV = 1'b1
  } lift_mode_t;

  typedef struct packed {
    logic sub;   // 1: base - term, 0: base + term
    logic half;  // 1: shift by one bit, 0: shift by two bits
  } pe_ctrl_t;

  localparam int unsigned NUM_PE = 2;

  // Element 0 predicts in forward and un-updates in inverse;
  // element 1 does the opposite role of the selected direction.
  function automatic pe_ctrl_t role_ctrl(lift_mode_t md, int unsigned idx);
    pe_ctrl_t c;
    logic predict;
    predict = ((md == MODE_FWD) == (idx == 0));
    c.half  = predict;
    c.sub   = predict ? (md == MODE_FWD) : (md == MODE_INV);
    return c;
  endfunction

endpackage

// File: rtl/lift_pe.sv
module lift_pe
  import lift53_pkg::*;
#(
  parameter int W = 11
) (
  input  logic signed [W-1:0] opa,
  input  logic signed [W-1:0] opb,
  input  logic signed [W-1:0] base,
  input  pe_ctrl_t            ctrl,
  output logic signed [W-1:0] res
);

  localparam int SW = W + 1;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] term;
  logic signed [W-1:0]  term_w;

  always_comb begin
    sum    = SW'(opa) + SW'(opb);
    term   = ctrl.half ? (sum >>> 1) : (sum >>> 2);
    term_w = term[W-1:0];
    res    = ctrl.sub ? (base - term_w) : (base + term_w);
  end

endmodule

// File: rtl/lift_split.sv
module lift_split #(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_data,
  output logic                pair_valid,
  input  logic                pair_ready,
  output logic signed [W-1:0] pair_even,
  output logic signed [W-1:0] pair_odd
);

  logic                have;
  logic signed [W-1:0] even_q;

  assign pair_valid = have && in_valid;
  assign pair_even  = even_q;
  assign pair_odd   = in_data;
  assign in_ready   = !have || pair_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have   <= 1'b0;
      even_q <= '0;
    end else if (in_valid && in_ready) begin
      if (!have) even_q <= in_data;
      have <= !have;
    end
  end

  // R2: an even sample accepted with no partner is held for the next odd one
  a_r2_even_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !have) |=> have);

endmodule

// File: rtl/lift_merge.sv
module lift_merge #(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                pair_valid,
  input  logic signed [W-1:0] pair_lo,
  input  logic signed [W-1:0] pair_hi,
  output logic                pair_take,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic signed [W-1:0] smp_data
);

  logic phase;  // 0: even word next, 1: odd word next

  assign smp_valid = en && pair_valid;
  assign smp_data  = en ? (phase ? pair_hi : pair_lo) : '0;
  assign pair_take = smp_valid && smp_ready && phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                       phase <= 1'b0;
    else if (smp_valid && smp_ready)  phase <= !phase;
  end

  // R3: every delivered sample flips the even/odd phase
  a_r3_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (phase != $past(phase)));

  // R5: a stalled sample stays put
  a_r5_smp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

endmodule

// File: rtl/lift53_core.sv
module lift53_core
  import lift53_pkg::*;
#(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                in_smp_valid,
  output logic                in_smp_ready,
  input  logic signed [W-1:0] in_smp_data,
  input  logic                in_cf_valid,
  output logic                in_cf_ready,
  input  logic signed [W-1:0] in_cf_lo,
  input  logic signed [W-1:0] in_cf_hi,
  output logic                out_cf_valid,
  input  logic                out_cf_ready,
  output logic signed [W-1:0] out_cf_lo,
  output logic signed [W-1:0] out_cf_hi,
  output logic                out_smp_valid,
  input  logic                out_smp_ready,
  output logic signed [W-1:0] out_smp_data
);

  lift_mode_t mode_e;
  logic       inv;
  assign mode_e = lift_mode_t'(mode);
  assign inv    = (mode_e == MODE_INV);

  // splitter (forward input path)
  logic                sp_valid, sp_ready, sp_in_ready;
  logic signed [W-1:0] sp_even, sp_odd;

  lift_split #(.W(W)) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_smp_valid && !inv),
    .in_ready   (sp_in_ready),
    .in_data    (in_smp_data),
    .pair_valid (sp_valid),
    .pair_ready (sp_ready),
    .pair_even  (sp_even),
    .pair_odd   (sp_odd)
  );

  // pipeline state
  logic signed [W-1:0] hist_a, hist_b;   // stage-0 history
  logic signed [W-1:0] mid_x, mid_y;     // register between elements
  logic                mid_v;
  logic signed [W-1:0] hist_g;           // stage-1 history
  logic signed [W-1:0] q_lo, q_hi;       // output pair
  logic                q_v;

  logic                p_valid;
  logic signed [W-1:0] p0, p1;
  logic                out_take, adv_q, adv_mid, mg_take;

  logic signed [W-1:0] pe_a [NUM_PE];
  logic signed [W-1:0] pe_b [NUM_PE];
  logic signed [W-1:0] pe_c [NUM_PE];
  logic signed [W-1:0] pe_r [NUM_PE];
  pe_ctrl_t            pe_k [NUM_PE];

  always_comb begin
    p_valid  = inv ? in_cf_valid : sp_valid;
    p0       = inv ? in_cf_lo    : sp_even;
    p1       = inv ? in_cf_hi    : sp_odd;
    pe_a[0]  = hist_a;
    pe_b[0]  = inv ? p1 : p0;
    pe_c[0]  = inv ? p0 : hist_b;
    pe_a[1]  = hist_g;
    pe_b[1]  = mid_x;
    pe_c[1]  = mid_y;
    out_take = inv ? mg_take : out_cf_ready;
    adv_q    = !q_v || out_take;
    adv_mid  = !mid_v || adv_q;
  end

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    assign pe_k[i] = role_ctrl(mode_e, i);
    lift_pe #(.W(W)) u_pe (
      .opa  (pe_a[i]),
      .opb  (pe_b[i]),
      .base (pe_c[i]),
      .ctrl (pe_k[i]),
      .res  (pe_r[i])
    );
  end

  assign sp_ready     = !inv && adv_mid;
  assign in_smp_ready = !inv && sp_in_ready;
  assign in_cf_ready  = inv && adv_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_a <= '0;
      hist_b <= '0;
      mid_x  <= '0;
      mid_y  <= '0;
      mid_v  <= 1'b0;
      hist_g <= '0;
      q_lo   <= '0;
      q_hi   <= '0;
      q_v    <= 1'b0;
    end else begin
      if (adv_mid) begin
        mid_v <= p_valid;
        if (p_valid) begin
          mid_x  <= pe_r[0];
          mid_y  <= hist_a;
          hist_a <= inv ? p1 : p0;
          hist_b <= p1;
        end
      end
      if (adv_q) begin
        q_v <= mid_v;
        if (mid_v) begin
          hist_g <= mid_x;
          q_lo   <= inv ? hist_g  : pe_r[1];
          q_hi   <= inv ? pe_r[1] : mid_x;
        end
      end
    end
  end

  assign out_cf_valid = !inv && q_v;
  assign out_cf_lo    = inv ? '0 : q_lo;
  assign out_cf_hi    = inv ? '0 : q_hi;

  lift_merge #(.W(W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (inv),
    .pair_valid (q_v),
    .pair_lo    (q_lo),
    .pair_hi    (q_hi),
    .pair_take  (mg_take),
    .smp_valid  (out_smp_valid),
    .smp_ready  (out_smp_ready),
    .smp_data   (out_smp_data)
  );

  // R5: a stalled coefficient pair stays put
  a_r5_cf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cf_valid && !out_cf_ready) |=>
      (out_cf_valid && $stable(out_cf_lo) && $stable(out_cf_hi)));

  // R6: the first cycle after reset shows no output traffic
  a_r6_quiet_after_reset: assert property (@(posedge clk)
    ($past(!rst_n) && rst_n) |-> (!out_cf_valid && !out_smp_valid));

  // R4: the idle direction's input is never acknowledged
  a_r4_idle_input: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_cf_ready && in_smp_ready));

endmodule

// File: tb/lift53_core_tb.sv
module lift53_core_tb;

  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic in_smp_valid = 1'b0;
  logic in_smp_ready;
  logic signed [W-1:0] in_smp_data = '0;
  logic in_cf_valid = 1'b0;
  logic in_cf_ready;
  logic signed [W-1:0] in_cf_lo = '0, in_cf_hi = '0;
  logic out_cf_valid;
  logic out_cf_ready = 1'b1;
  logic signed [W-1:0] out_cf_lo, out_cf_hi;
  logic out_smp_valid;
  logic out_smp_ready = 1'b1;
  logic signed [W-1:0] out_smp_data;

  always #2 clk = ~clk;  // 250 MHz

  lift53_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_smp_valid(in_smp_valid), .in_smp_ready(in_smp_ready), .in_smp_data(in_smp_data),
    .in_cf_valid(in_cf_valid), .in_cf_ready(in_cf_ready), .in_cf_lo(in_cf_lo), .in_cf_hi(in_cf_hi),
    .out_cf_valid(out_cf_valid), .out_cf_ready(out_cf_ready), .out_cf_lo(out_cf_lo), .out_cf_hi(out_cf_hi),
    .out_smp_valid(out_smp_valid), .out_smp_ready(out_smp_ready), .out_smp_data(out_smp_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  int smp_in [128];
  int ex_lo [64];
  int ex_hi [64];
  int cap_lo [128];
  int cap_hi [128];
  int cap_s [256];
  int cap_n = 0;
  int cap_sn = 0;

  logic bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wr(input int v);
    return ((v + 1024) & 2047) - 1024;
  endfunction

  // back-pressure pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_cf_ready  = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
    out_smp_ready = bp_on ? (lfsr[2] | lfsr[7]) : 1'b1;
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (out_cf_valid && out_cf_ready && cap_n < 128) begin
      cap_lo[cap_n] = int'(out_cf_lo);
      cap_hi[cap_n] = int'(out_cf_hi);
      cap_n++;
    end
    if (out_smp_valid && out_smp_ready && cap_sn < 256) begin
      cap_s[cap_sn] = int'(out_smp_data);
      cap_sn++;
    end
  end

  task automatic do_reset(input logic md);
    @(negedge clk);
    rst_n = 1'b0;
    mode = md;
    in_smp_valid = 1'b0;
    in_cf_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cap_n = 0;
    cap_sn = 0;
  endtask

  task automatic push_smp(input int v);
    in_smp_valid = 1'b1;
    in_smp_data = W'(v);
    #1;
    while (!in_smp_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_smp_valid = 1'b0;
  endtask

  task automatic push_cf(input int lo, input int hi);
    in_cf_valid = 1'b1;
    in_cf_lo = W'(lo);
    in_cf_hi = W'(hi);
    #1;
    while (!in_cf_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_cf_valid = 1'b0;
  endtask

  task automatic wait_cf(input int n);
    int i = 0;
    while (cap_n < n && i < 3000) begin @(negedge clk); i++; end
    #2;
  endtask

  task automatic wait_smp(input int n);
    int i = 0;
    while (cap_sn < n && i < 6000) begin @(negedge clk); i++; end
    #2;
  endtask

  // forward model built from the lifting equations
  task automatic model_fwd(input int n);
    int ep = 0, op = 0, dp = 0;
    for (int k = 0; k < n / 2; k++) begin
      int e = smp_in[2*k];
      int o = smp_in[2*k+1];
      int d = wr(op - ((ep + e) >>> 1));
      int a = wr(ep + ((dp + d) >>> 2));
      ex_lo[k] = a;
      ex_hi[k] = d;
      dp = d; ep = e; op = o;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    #1;
    chk("R6 cf valid after reset", int'(out_cf_valid), 0);
    chk("R6 smp valid after reset", int'(out_smp_valid), 0);
    chk("R6 cf lo after reset", int'(out_cf_lo), 0);
    chk("R6 cf hi after reset", int'(out_cf_hi), 0);
  endtask

  // R1 R2 R7: floor rounding of negative sums and output timing
  task automatic t_directed();
    do_reset(1'b0);
    push_smp(-3);
    push_smp(5);
    #1;
    chk("R7 not valid one cycle after odd", int'(out_cf_valid), 0);
    @(negedge clk); #1;
    chk("R7 valid two cycles after odd", int'(out_cf_valid), 1);
    chk("R1 R2 first lo", int'(out_cf_lo), 0);
    chk("R1 R2 first hi", int'(out_cf_hi), 2);
    @(negedge clk);
    push_smp(0);
    push_smp(0);
    wait_cf(2);
    chk("R2 pair count", cap_n, 2);
    chk("R1 R2 second lo", cap_lo[1], -1);
    chk("R1 R2 second hi", cap_hi[1], 7);
  endtask

  // R2 R3 R4 R5: forward, then feed coefficients back through inverse
  task automatic t_roundtrip(input int n, input logic bp, input string tag);
    int np = n / 2;
    int bad = 0;
    model_fwd(n);
    bp_on = bp;
    do_reset(1'b0);
    // stray coefficient traffic while forward
    in_cf_valid = 1'b1; in_cf_lo = 11'sd100; in_cf_hi = -11'sd50;
    repeat (3) begin
      @(negedge clk); #1;
      chk({"R4 fwd cf ready ", tag}, int'(in_cf_ready), 0);
      chk({"R4 fwd smp valid ", tag}, int'(out_smp_valid), 0);
      chk({"R4 fwd smp data ", tag}, int'(out_smp_data), 0);
    end
    in_cf_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) push_smp(smp_in[i]);
    wait_cf(np);
    chk({"R2 R5 fwd count ", tag}, cap_n, np);
    for (int k = 0; k < np; k++) begin
      if (cap_lo[k] != ex_lo[k] || cap_hi[k] != ex_hi[k]) begin
        bad++;
        $display("FAIL R2 R5 %s pair %0d actual=(%0d,%0d) expected=(%0d,%0d)",
                 tag, k, cap_lo[k], cap_hi[k], ex_lo[k], ex_hi[k]);
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    for (int k = 0; k < np; k++) begin ex_lo[k] = cap_lo[k]; ex_hi[k] = cap_hi[k]; end

    do_reset(1'b1);
    in_smp_valid = 1'b1; in_smp_data = 11'sd77;
    repeat (3) begin
      @(negedge clk); #1;
      chk({"R4 inv smp ready ", tag}, int'(in_smp_ready), 0);
      chk({"R4 inv cf valid ", tag}, int'(out_cf_valid), 0);
      chk({"R4 inv cf lo ", tag}, int'(out_cf_lo), 0);
    end
    in_smp_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < np; k++) push_cf(ex_lo[k], ex_hi[k]);
    wait_smp(n);
    chk({"R3 R5 inv count ", tag}, cap_sn, n);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      int e = (i < 4) ? 0 : smp_in[i-4];
      if (cap_s[i] != e) begin
        bad++;
        $display("FAIL R3 R5 %s sample %0d actual=%0d expected=%0d", tag, i, cap_s[i], e);
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    bp_on = 1'b0;
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_directed();

    for (int i = 0; i < 40; i++) smp_in[i] = ((i * 37 + 11) % 256) - 128;
    t_roundtrip(40, 1'b0, "ramp");

    for (int i = 0; i < 48; i++) smp_in[i] = ((i * 73 + i * i * 5 + 3) % 256) - 128;
    t_roundtrip(48, 1'b1, "bp");

    for (int i = 0; i < 24; i++) smp_in[i] = (i % 3 == 0) ? -1024 : ((i % 3 == 1) ? 1023 : -1);
    t_roundtrip(24, 1'b1, "extreme");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule